// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-pin general-purpose I/O port that sits behind a small word-addressed register bus with separate read and write strobes. It holds a pin data register and a direction register. The pins marked as outputs are driven from the data register. The pins marked as inputs are sampled into the data register on every clock edge and appear on the output pins as logic high.

Any access to the data window uses the address itself as a bit mask: address bits [9:2] pick which pins a read returns or a write may touch. Software can therefore set, clear or sample any subset of pins in one bus cycle, with no read-modify-write sequence. When a software write or a direction change moves the driven level on any pin, the block raises a one-cycle change pulse together with the vector of pins that moved. Twelve fixed identification bytes can be read from the top of the 4 KiB space. A read of an unmapped offset returns zero and latches a sticky error flag.

The bus has no back-pressure. Every strobe is accepted in the cycle it is presented, and read data arrives one cycle later, marked by a one-cycle valid pulse.

Top module: `amgpio_port`

## Requirements
- R1: A read at a byte offset below 0x400 returns, one cycle later, the data register ANDed with address bits [9:2]. Pins not selected by the mask, and bits [31:8], read as zero.
- R2: A write at a byte offset below 0x400 changes only the data bits that are set both in address bits [9:2] and in the direction register. Those bits take the value of the matching bits of the write data, and every other bit is unaffected by the write.
- R3: The direction register is at byte offset 0x400. A write there stores write data bits [7:0], and a read there returns that value zero-extended. A 1 in bit i makes pin i an output.
- R4: Output pin i carries data bit i when direction bit i is 1, and carries logic 1 when direction bit i is 0.
- R5: For every pin whose direction bit is 0, the data register takes the level of that input pin at each clock edge. The input level of a pin whose direction bit is 1 has no effect on the data register.
- R6: Reads at byte offsets 0xFD0, 0xFD4, …, 0xFFC return one identification byte each, zero-extended, in this order: 00, 00, 00, 00, 61, 10, 04, 00, 0D, F0, 05, B1.
- R7: In the cycle right after the driven output vector changes, `out_change` is 1 for exactly one cycle and `out_changed` holds the XOR of the new and old output vectors. When the vector does not change, `out_change` stays 0.
- R8: A read at any offset outside the data window, the direction register and the identification range returns zero and sets `bad_access`. `bad_access` stays set until reset. A write to such an offset changes neither register.
- R9: After reset the data and direction registers are zero, every pin drives 1, `out_change`, `bus_rvalid` and `bad_access` are 0, and `bus_rdata` is zero.
- R10: `bus_rvalid` is 1 in the cycle after each cycle with `bus_rd` high, and 0 otherwise. `bus_rdata` holds the value read during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_addr | input | 12 | Byte offset; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data; only [7:0] used |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| pin_in | input | 8 | Sampled pin levels |
| pin_out | output | 8 | Driven pin levels |
| out_change | output | 1 | One-cycle pulse when `pin_out` moved |
| out_changed | output | 8 | Pins that moved, valid with `out_change` |
| bad_access | output | 1 | Sticky flag for reads of unmapped offsets |

## Verification
The masked data path is exercised with sparse masks (0x05, 0x03, 0x30), the full mask 0xFF, and masks that cover only input pins. These patterns separate a design that honours the address mask from one that writes whole bytes, and a design that also gates writes by direction from one that does not. Input levels are applied to both input and output pins, which shows that capture follows the direction register and not the address mask. Direction writes of an unchanged value, and data writes that reach only input pins, check that the change pulse fires on a real level change and on nothing else.

// File: rtl/amgpio_pkg.sv
package amgpio_pkg;

  localparam int ID_COUNT = 12;

  function automatic logic [7:0] id_byte(input logic [3:0] idx);
    logic [7:0] b;
    case (idx)
      4'd4:    b = 8'h61;
      4'd5:    b = 8'h10;
      4'd6:    b = 8'h04;
      4'd8:    b = 8'h0D;
      4'd9:    b = 8'hF0;
      4'd10:   b = 8'h05;
      4'd11:   b = 8'hB1;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/amgpio_regs.sv
module amgpio_regs #(
  parameter int PIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_we,
  input  logic             dir_we,
  input  logic [PIN_W-1:0] wr_mask,
  input  logic [PIN_W-1:0] wdata,
  input  logic [PIN_W-1:0] pin_in,
  output logic [PIN_W-1:0] data_q,
  output logic [PIN_W-1:0] dir_q
);

  logic [PIN_W-1:0] sel_w;
  logic [PIN_W-1:0] after_wr;
  logic [PIN_W-1:0] data_d;

  assign sel_w    = data_we ? (wr_mask & dir_q) : '0;
  assign after_wr = (data_q & ~sel_w) | (wdata & sel_w);
  assign data_d   = (after_wr & dir_q) | (pin_in & ~dir_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      data_q <= data_d;
      if (dir_we) dir_q <= wdata;
    end
  end

  AST_WRITE_KEEPS_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |=> (((data_q ^ $past(data_q)) & $past(dir_q) & ~$past(wr_mask)) == '0)); // R2

  AST_OUTPUT_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !data_we |=> (((data_q ^ $past(data_q)) & $past(dir_q)) == '0)); // R5

  AST_INPUT_BITS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((data_q ^ $past(pin_in)) & ~$past(dir_q)) == '0)); // R5

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_we |=> $stable(dir_q)); // R3

endmodule

// File: rtl/amgpio_pinout.sv
module amgpio_pinout #(
  parameter int PIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] data_q,
  input  logic [PIN_W-1:0] dir_q,
  output logic [PIN_W-1:0] pin_out,
  output logic             out_change,
  output logic [PIN_W-1:0] out_changed
);

  logic [PIN_W-1:0] prev_q;

  for (genvar i = 0; i < PIN_W; i++) begin : g_pin
    assign pin_out[i] = dir_q[i] ? data_q[i] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= pin_out;
  end

  assign out_changed = pin_out ^ prev_q;
  assign out_change  = |out_changed;

  AST_CHANGE_TRACKS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_change == (pin_out != $past(pin_out)))); // R7

  AST_INPUTS_FLOAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((~dir_q & ~pin_out) == '0)); // R4

endmodule

// File: rtl/amgpio_rdmux.sv
module amgpio_rdmux
  import amgpio_pkg::*;
#(
  parameter int PIN_W  = 8,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PIN_W-1:0]  data_q,
  input  logic [PIN_W-1:0]  dir_q,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              bad
);

  localparam int WORD_W  = ADDR_W - 2;
  localparam int MASK_LO = 2;
  localparam int MASK_HI = MASK_LO + PIN_W - 1;
  localparam int DIR_WD  = 1 << PIN_W;
  localparam int ID_BASE = (1 << WORD_W) - ID_COUNT;

  logic [WORD_W-1:0] word;
  logic [DATA_W-1:0] rd_val;
  logic              hit;
  logic              unused_lo;

  assign word      = addr[ADDR_W-1:2];
  assign unused_lo = ^addr[1:0];

  always_comb begin
    rd_val = '0;
    hit    = 1'b1;
    if (int'(word) < DIR_WD) begin
      rd_val[PIN_W-1:0] = data_q & addr[MASK_HI:MASK_LO];
    end else if (int'(word) == DIR_WD) begin
      rd_val[PIN_W-1:0] = dir_q;
    end else if (int'(word) >= ID_BASE) begin
      rd_val[7:0] = id_byte(4'(int'(word) - ID_BASE));
    end else begin
      hit = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
      bad    <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= rd_val;
      if (rd && !hit) bad <= 1'b1;
    end
  end

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rvalid == $past(rd))); // R10

  AST_UNSELECTED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && int'(word) < DIR_WD) |=>
      (((rdata[PIN_W-1:0] & ~$past(addr[MASK_HI:MASK_LO])) == '0) &&
       (rdata[DATA_W-1:PIN_W] == '0))); // R1

  AST_BAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> bad); // R8

endmodule

// File: rtl/amgpio_port.sv
module amgpio_port #(
  parameter int PIN_W  = 8,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic              out_change,
  output logic [PIN_W-1:0]  out_changed,
  output logic              bad_access
);

  localparam int MASK_LO = 2;
  localparam int MASK_HI = MASK_LO + PIN_W - 1;
  localparam int DIR_WD  = 1 << PIN_W;

  logic [ADDR_W-3:0] wr_word;
  logic              data_we;
  logic              dir_we;
  logic [PIN_W-1:0]  data_q;
  logic [PIN_W-1:0]  dir_q;
  logic              unused_wd;

  assign wr_word   = bus_addr[ADDR_W-1:2];
  assign data_we   = bus_wr && (int'(wr_word) < DIR_WD);
  assign dir_we    = bus_wr && (int'(wr_word) == DIR_WD);
  assign unused_wd = ^bus_wdata[DATA_W-1:PIN_W];

  amgpio_regs #(.PIN_W(PIN_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .data_we (data_we),
    .dir_we  (dir_we),
    .wr_mask (bus_addr[MASK_HI:MASK_LO]),
    .wdata   (bus_wdata[PIN_W-1:0]),
    .pin_in  (pin_in),
    .data_q  (data_q),
    .dir_q   (dir_q)
  );

  amgpio_pinout #(.PIN_W(PIN_W)) u_pinout (
    .clk         (clk),
    .rst_n       (rst_n),
    .data_q      (data_q),
    .dir_q       (dir_q),
    .pin_out     (pin_out),
    .out_change  (out_change),
    .out_changed (out_changed)
  );

  amgpio_rdmux #(.PIN_W(PIN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rdmux (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd     (bus_rd),
    .addr   (bus_addr),
    .data_q (data_q),
    .dir_q  (dir_q),
    .rdata  (bus_rdata),
    .rvalid (bus_rvalid),
    .bad    (bad_access)
  );

  AST_UNMAPPED_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !data_we && !dir_we && !bus_rd) |=> ($stable(dir_q) && ($past(dir_q) == dir_q))); // R8

endmodule

// File: tb/amgpio_port_bench.sv
module amgpio_port_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out;
  logic        out_change;
  logic [7:0]  out_changed;
  logic        bad_access;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic        last_chg;
  logic [7:0]  last_vec;
  logic [31:0] rd_res;
  logic        rd_vld;
  logic [7:0]  exp_id [12];

  always #2 clk = ~clk;

  amgpio_port u_amgpio_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out),
    .out_change(out_change), .out_changed(out_changed), .bad_access(bad_access)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    last_chg = out_change; last_vec = out_changed;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    rd_res = bus_rdata; rd_vld = bus_rvalid;
    bus_rd = 1'b0;
  endtask

  function automatic logic [11:0] mask_addr(input logic [7:0] m);
    return {2'b00, m, 2'b00};
  endfunction

  task automatic t_reset;
    chk("R9 pin_out", {24'b0, pin_out}, 32'hFF);
    chk("R9 out_change", {31'b0, out_change}, 0);
    chk("R9 rvalid", {31'b0, bus_rvalid}, 0);
    chk("R9 bad_access", {31'b0, bad_access}, 0);
    chk("R9 rdata", bus_rdata, 0);
    bus_read(12'h400);
    chk("R9 dir reset", rd_res, 0);
  endtask

  task automatic t_dir;
    bus_write(12'h400, 32'hFFFF_FF0F);
    chk("R7 pulse on dir", {31'b0, last_chg}, 1);
    chk("R7 vector on dir", {24'b0, last_vec}, 32'h0F);
    chk("R4 outputs low", {24'b0, pin_out}, 32'hF0);
    bus_read(12'h400);
    chk("R3 dir readback", rd_res, 32'h0F);
    bus_write(12'h400, 32'h0F);
    chk("R7 no pulse same dir", {31'b0, last_chg}, 0);
  endtask

  task automatic t_masked_write;
    bus_write(mask_addr(8'h05), 32'hFF);
    chk("R2 sparse set", {24'b0, pin_out}, 32'hF5);
    chk("R7 vector sparse", {24'b0, last_vec}, 32'h05);
    bus_write(mask_addr(8'hF0), 32'hFF);
    chk("R2 input-only mask", {24'b0, pin_out}, 32'hF5);
    chk("R7 no pulse input-only", {31'b0, last_chg}, 0);
    bus_write(mask_addr(8'h03), 32'h00);
    chk("R2 partial clear", {24'b0, pin_out}, 32'hF4);
    @(negedge clk);
    chk("R7 single cycle", {31'b0, out_change}, 0);
  endtask

  task automatic t_masked_read;
    @(negedge clk); pin_in = 8'hA0;
    bus_read(mask_addr(8'hFF));
    chk("R5 capture full", rd_res, 32'hA4);
    chk("R10 rvalid", {31'b0, rd_vld}, 1);
    @(negedge clk);
    chk("R10 rvalid drops", {31'b0, bus_rvalid}, 0);
    bus_read(mask_addr(8'h30));
    chk("R1 sparse read", rd_res, 32'h20);
    @(negedge clk); pin_in = 8'hAF;
    bus_read(mask_addr(8'h0F));
    chk("R5 output pins ignore input", rd_res, 32'h04);
    chk("R4 output pins hold", {24'b0, pin_out}, 32'hF4);
  endtask

  task automatic t_id;
    for (int k = 0; k < 12; k++) begin
      bus_read(12'hFD0 + 12'(4 * k));
      chk($sformatf("R6 id byte %0d", k), rd_res, {24'b0, exp_id[k]});
    end
    chk("R8 id no error", {31'b0, bad_access}, 0);
  endtask

  task automatic t_unmapped;
    bus_write(12'h404, 32'hFF);
    bus_read(12'h400);
    chk("R8 unmapped write inert", rd_res, 32'h0F);
    chk("R8 pins unchanged", {24'b0, pin_out}, 32'hF4);
    chk("R8 write no flag", {31'b0, bad_access}, 0);
    bus_read(12'h800);
    chk("R8 unmapped read zero", rd_res, 0);
    chk("R8 flag set", {31'b0, bad_access}, 1);
    bus_read(12'h400);
    chk("R8 flag sticky", {31'b0, bad_access}, 1);
  endtask

  initial begin
    exp_id = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h61, 8'h10,
               8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dir();
    t_masked_write();
    t_masked_read();
    t_id();
    t_unmapped();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule